// File: doc/BRIEF.md
# Transmit multiframe event generator

This block follows the frames leaving a transmit framer and tells the host when the overhead and signaling data for the next multiframe must be refreshed. It receives one strobe per transmitted frame and keeps a single frame counter. From that counter it derives the boundaries of several multiframe lengths. Which boundaries are reported depends on the selected line mode.

In 1.5 Mb/s mode the multiframe event marks every 12th frame (1.5 ms) or, with the long multiframe selected, every 24th frame (3 ms). When its enable is set, a superframe event also marks every 72nd frame. In 2 Mb/s mode the multiframe event marks every 16th frame (2 ms), and the long-multiframe select has no effect there. An alignment event marks every second frame (250 µs), and the superframe event is never produced. Each event is a one-cycle pulse. It also sets a sticky status bit, which the host clears by writing a one to it.

Top module: `tx_mframe_evt`

## Requirements
- R1: With `line_e1`=0 and `long_mf`=0, `mf_pulse` fires for the 12th, 24th, 36th ... frame strobe counted from reset or from the last mode change, and for no other strobe.
- R2: With `line_e1`=0 and `long_mf`=1, `mf_pulse` fires for every 24th frame strobe.
- R3: With `line_e1`=1, `mf_pulse` fires for every 16th frame strobe, whatever the value of `long_mf`.
- R4: With `line_e1`=1, `align_pulse` fires for every even-numbered frame strobe (2nd, 4th, ...). With `line_e1`=0 it never fires.
- R5: With `line_e1`=0 and `super_en`=1, `super_pulse` fires for every 72nd frame strobe. It never fires when `super_en`=0 or `line_e1`=1.
- R6: Every pulse is high for exactly the one clock cycle that follows the rising edge at which `frame_stb` was sampled high. No pulse occurs without a strobe.
- R7: `evt_sts` bit 0 (multiframe), bit 1 (alignment) and bit 2 (superframe) are set by their event pulse. Each bit holds until a cycle in which the same bit of `sts_clr` is 1. A clear of one bit leaves the other bits unchanged.
- R8: When an event and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R9: A change of `line_e1` resets the frame count to zero. A strobe sampled in the cycle of the change produces no event and is not counted.
- R10: While `rst_n` is low, all pulses and `evt_sts` are 0, and the frame count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per transmitted frame |
| line_e1 | input | 1 | Line mode: 0 = 1.5 Mb/s, 1 = 2 Mb/s |
| long_mf | input | 1 | Selects the 24-frame multiframe in 1.5 Mb/s mode |
| super_en | input | 1 | Enables the 72-frame superframe event |
| sts_clr | input | 3 | Write-one-to-clear strobes for `evt_sts` |
| mf_pulse | output | 1 | Multiframe boundary pulse |
| align_pulse | output | 1 | Alignment-frame pulse (2 Mb/s mode) |
| super_pulse | output | 1 | Superframe boundary pulse (1.5 Mb/s mode) |
| evt_sts | output | 3 | Sticky status: bit 0 multiframe, bit 1 alignment, bit 2 superframe |

## Verification
The bench builds the block with its default lengths of 12, 24, 16 and 72 frames. With these values a full superframe wrap fits in 72 strobes, so runs of 144 frames pass the counter's wrap point twice and show that the 12- and 24-frame boundaries stay aligned across it. In the 16-frame mode, runs of 32 and 48 frames cover the shorter wrap. Directed tests switch the line mode in the middle of a multiframe, which shows the restart, and set a clear in the same cycle as a boundary event.

// File: rtl/tx_mframe_evt.sv
module tx_mframe_evt #(
  parameter int MF_SHORT  = 12,
  parameter int MF_LONG   = 24,
  parameter int MF_E1     = 16,
  parameter int SUPER_LEN = 72
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       line_e1,
  input  logic       long_mf,
  input  logic       super_en,
  input  logic [2:0] sts_clr,
  output logic       mf_pulse,
  output logic       align_pulse,
  output logic       super_pulse,
  output logic [2:0] evt_sts
);
  localparam int TOP = (SUPER_LEN > MF_E1) ? SUPER_LEN : MF_E1;
  localparam int CW  = $clog2(TOP);
  localparam logic [CW-1:0] SHORT_N   = CW'(MF_SHORT);
  localparam logic [CW-1:0] LONG_N    = CW'(MF_LONG);
  localparam logic [CW-1:0] SHORT_END = CW'(MF_SHORT - 1);
  localparam logic [CW-1:0] LONG_END  = CW'(MF_LONG - 1);
  localparam logic [CW-1:0] E1_END    = CW'(MF_E1 - 1);
  localparam logic [CW-1:0] SUP_END   = CW'(SUPER_LEN - 1);

  logic [CW-1:0] cnt;
  logic          mode_q;

  // mode change suppresses counting and events for that cycle
  wire mode_chg = line_e1 != mode_q;
  wire hit      = frame_stb & ~mode_chg;

  wire [CW-1:0] wrap_at = line_e1 ? E1_END : SUP_END;
  wire at_wrap  = cnt == wrap_at;

  wire short_end = (cnt % SHORT_N) == SHORT_END;
  wire long_end  = (cnt % LONG_N)  == LONG_END;
  wire mf_end    = line_e1 ? at_wrap : (long_mf ? long_end : short_end);

  wire mf_now    = hit & mf_end;
  wire align_now = hit & line_e1 & cnt[0];
  wire super_now = hit & ~line_e1 & super_en & at_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= line_e1;
      if (mode_chg)
        cnt <= '0;
      else if (frame_stb)
        cnt <= at_wrap ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_pulse    <= 1'b0;
      align_pulse <= 1'b0;
      super_pulse <= 1'b0;
      evt_sts     <= '0;
    end else begin
      mf_pulse    <= mf_now;
      align_pulse <= align_now;
      super_pulse <= super_now;
      evt_sts     <= (evt_sts & ~sts_clr) | {super_now, align_now, mf_now};
    end
  end
endmodule

module tx_mframe_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic       line_e1,
  input logic       super_en,
  input logic [2:0] sts_clr,
  input logic       mf_pulse,
  input logic       align_pulse,
  input logic       super_pulse,
  input logic [2:0] evt_sts
);
  // R6
  pulse_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_pulse || align_pulse || super_pulse) |-> $past(frame_stb));

  // R4
  align_only_e1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |-> $past(line_e1));

  // R5
  super_only_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    super_pulse |-> (!$past(line_e1) && $past(super_en)));

  // R6
  align_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |=> !align_pulse);

  // R7
  mf_sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_sts[0]) |-> mf_pulse);

  // R7
  mf_sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_sts[0]) && !$past(sts_clr[0])) |-> evt_sts[0]);

  // R8
  sts_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_pulse |-> evt_sts[0]);

  // R9
  mode_chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_e1 != $past(line_e1)) |=> (!mf_pulse && !align_pulse && !super_pulse));
endmodule

bind tx_mframe_evt tx_mframe_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_e1(line_e1),
  .super_en(super_en), .sts_clr(sts_clr), .mf_pulse(mf_pulse),
  .align_pulse(align_pulse), .super_pulse(super_pulse), .evt_sts(evt_sts)
);

// File: tb/tx_mframe_evt_tb.sv
module tx_mframe_evt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0, line_e1 = 1'b0, long_mf = 1'b0, super_en = 1'b0;
  logic [2:0] sts_clr = 3'b000;
  logic mf_pulse, align_pulse, super_pulse;
  logic [2:0] evt_sts;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_mframe_evt u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_e1(line_e1),
    .long_mf(long_mf), .super_en(super_en), .sts_clr(sts_clr),
    .mf_pulse(mf_pulse), .align_pulse(align_pulse), .super_pulse(super_pulse),
    .evt_sts(evt_sts)
  );

  // fields: e1, long, super_en, frames, mf count, align count, super count
  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{0, 0, 0,  72,  6,  0, 0},
    '{0, 1, 1,  72,  3,  0, 1},
    '{0, 0, 1, 144, 12,  0, 2},
    '{1, 0, 1,  48,  3, 24, 0},
    '{1, 1, 0,  32,  2, 16, 0},
    '{0, 0, 0,  11,  0,  0, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_stb = 1'b0;
    sts_clr = 3'b000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame(output logic m, output logic a, output logic s);
    frame_stb = 1'b1;
    @(negedge clk);
    m = mf_pulse; a = align_pulse; s = super_pulse;
    frame_stb = 1'b0;
    sts_clr = 3'b000;
    @(negedge clk);
  endtask

  function automatic bit exp_mf(input bit e1, input bit lng, input int k);
    if (e1) return (k % 16) == 0;
    return lng ? (k % 24) == 0 : (k % 12) == 0;
  endfunction

  initial begin
    logic m, a, s;
    int cm, ca, cs;

    // R10: reset state
    rst_n = 1'b0;
    frame_stb = 1'b1;
    repeat (3) @(negedge clk);
    check({mf_pulse, align_pulse, super_pulse, evt_sts} == 6'b0, "R10 reset outputs",
          int'({mf_pulse, align_pulse, super_pulse, evt_sts}), 0);
    frame_stb = 1'b0;

    // table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      line_e1 = VEC[v][0][0]; long_mf = VEC[v][1][0]; super_en = VEC[v][2][0];
      do_reset();
      cm = 0; ca = 0; cs = 0;
      for (int k = 1; k <= VEC[v][3]; k++) begin
        bit em, ea, es;
        frame(m, a, s);
        em = exp_mf(line_e1, long_mf, k);
        ea = line_e1 && (k % 2 == 0);
        es = !line_e1 && super_en && (k % 72 == 0);
        check(m == em, "R1/R2/R3 mf_pulse per frame", m, em);
        check(a == ea, "R4 align_pulse per frame", a, ea);
        check(s == es, "R5 super_pulse per frame", s, es);
        cm += m; ca += a; cs += s;
      end
      check(cm == VEC[v][4], "R1 R2 R3 mf count", cm, VEC[v][4]);
      check(ca == VEC[v][5], "R4 align count", ca, VEC[v][5]);
      check(cs == VEC[v][6], "R5 super count", cs, VEC[v][6]);
    end

    // R6: no strobe, no pulse; pulse lasts one cycle
    line_e1 = 1'b0; long_mf = 1'b0; super_en = 1'b0;
    do_reset();
    for (int k = 1; k <= 11; k++) frame(m, a, s);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    check(mf_pulse == 1'b1, "R6 pulse after strobe", mf_pulse, 1);
    @(negedge clk);
    check(mf_pulse == 1'b0, "R6 pulse one cycle", mf_pulse, 0);
    repeat (5) @(negedge clk);
    check({mf_pulse, align_pulse, super_pulse} == 3'b0, "R6 idle no pulse",
          int'({mf_pulse, align_pulse, super_pulse}), 0);

    // R7: sticky status, per-bit clear
    check(evt_sts == 3'b001, "R7 mf status latched", evt_sts, 1);
    sts_clr = 3'b110;
    @(negedge clk);
    sts_clr = 3'b000;
    check(evt_sts == 3'b001, "R7 other-bit clear no effect", evt_sts, 1);
    sts_clr = 3'b001;
    @(negedge clk);
    sts_clr = 3'b000;
    check(evt_sts == 3'b000, "R7 clear mf status", evt_sts, 0);

    // R8: event in the clear cycle wins
    for (int k = 1; k <= 11; k++) frame(m, a, s);
    check(evt_sts == 3'b000, "R8 no status before boundary", evt_sts, 0);
    sts_clr = 3'b001;
    frame(m, a, s);
    check(evt_sts[0] == 1'b1, "R8 event wins over clear", evt_sts[0], 1);

    // R9: mode change restarts the count
    do_reset();
    for (int k = 1; k <= 5; k++) frame(m, a, s);
    line_e1 = 1'b1;
    @(negedge clk);
    cm = 0;
    for (int k = 1; k <= 16; k++) begin
      frame(m, a, s);
      if (m) cm = k;
    end
    check(cm == 16, "R9 e1 restart mf frame", cm, 16);
    for (int k = 1; k <= 3; k++) frame(m, a, s);
    line_e1 = 1'b0;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    check({mf_pulse, align_pulse} == 2'b0, "R9 strobe on change ignored",
          int'({mf_pulse, align_pulse}), 0);
    @(negedge clk);
    cm = 0;
    for (int k = 1; k <= 12; k++) begin
      frame(m, a, s);
      if (m) cm = k;
    end
    check(cm == 12, "R9 t1 restart mf frame", cm, 12);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule